// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block sits behind a serial-memory protocol engine and collects the data bytes of one write transaction in a page-wide staging buffer. A transaction opens with a start address. The upper address bits choose a page, which is held for the whole transaction, and the lower bits give the first byte slot. Each accepted data byte lands in the current slot, and the slot pointer then advances. When the pointer steps past the last slot of the page it returns to slot zero of the same page. It never moves into the next page, so an overlong burst overwrites the bytes it stored earlier.

A commit request, which the protocol engine issues on STOP, starts a timed write cycle. A busy flag stays high for a parameterised number of clocks. When the count expires, every staged byte is written into the array in the same clock. A per-slot valid mask records which slots received data, and only those bytes of the page change. An abort, or a commit with nothing staged, drops the staged data without starting a cycle. A combinational read port gives access to the array contents.

Top module: `page_wrbuf`

## Requirements
- R1: After reset, busy_o is 0 and every byte of the array reads 8'hFF.
- R2: The array address is split into a page number (upper ADDR_W-log2(PAGE_BYTES) bits) and a slot offset (lower log2(PAGE_BYTES) bits). While idle, a load pulse captures the page and the starting slot from start_addr_i and empties the valid mask. The page does not change until the next accepted load.
- R3: Each accepted byte is staged at the current slot, and that slot is marked valid. The slot pointer then increments modulo PAGE_BYTES, so slot PAGE_BYTES-1 is followed by slot 0 of the same page.
- R4: When more than PAGE_BYTES bytes are staged, a later byte replaces the earlier byte held at the same slot.
- R5: An idle commit with at least one valid slot raises busy_o on the next clock. busy_o stays high for exactly TWR_CYCLES clocks, and the array contents do not change while it is high.
- R6: On the clock edge at which busy_o falls, all valid slots are written to the latched page together. Slots that were not loaded keep their previous array values, and the valid mask is cleared.
- R7: An idle abort empties the valid mask and starts no cycle. An idle commit with an empty mask leaves busy_o low and the array unchanged.
- R8: While busy_o is high, load, byte, commit and abort inputs are ignored. The page, the slot pointer and the valid mask keep their values.
- R9: When several inputs are high in the same idle cycle, only one takes effect, in the order abort, commit, load, byte.
- R10: With RD_LATENCY = 0, rd_data_o shows the array byte at rd_addr_i combinationally. With RD_LATENCY = 1, it shows that byte one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Opens a transaction at start_addr_i |
| start_addr_i | input | ADDR_W | Start address: page plus starting slot |
| byte_valid_i | input | 1 | Strobe for one data byte |
| byte_i | input | 8 | Data byte |
| abort_i | input | 1 | Drops the staged bytes |
| commit_i | input | 1 | Starts the timed write cycle |
| busy_o | output | 1 | High during the write cycle |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
The staging path is exercised with several kinds of burst:
- A short burst from slot zero shows the basic store and commit, and confirms that the untouched slots stay 8'hFF.
- A burst that starts near the page end shows whether the pointer wraps inside the page or carries into the next page, which is read back to confirm it is untouched.
- An overlong burst separates "last writer wins" from "first writer wins" at the overwritten slots.
- A one-byte rewrite of an already written page shows that the mask protects the other bytes.

Inputs applied during busy, and inputs that collide in one cycle, are checked afterwards at the read port and by the behaviour of a follow-up commit. These checks show whether the ignored or lower-priority input disturbed the mask, the pointer or the page.

// File: rtl/page_wrbuf_pkg.sv
package page_wrbuf_pkg;

   localparam int unsigned BYTE_W = 8;

   // One accepted action per idle cycle, highest priority first.
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_ABORT,
      OP_COMMIT,
      OP_LOAD,
      OP_BYTE
   } pwb_op_e;

   function automatic pwb_op_e pick_op(input logic ab, input logic cm,
                                       input logic ld, input logic st);
      pwb_op_e op;
      if (ab)      op = OP_ABORT;
      else if (cm) op = OP_COMMIT;
      else if (ld) op = OP_LOAD;
      else if (st) op = OP_BYTE;
      else         op = OP_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/pwb_loader.sv
module pwb_loader
   import page_wrbuf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned PAGE_BYTES = 32,
   localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
   localparam int unsigned PAGE_W    = ADDR_W - OFF_W
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  pwb_op_e                            op_i,
   input  logic [ADDR_W-1:0]                  start_addr_i,
   input  logic [BYTE_W-1:0]                  byte_i,
   input  logic                               clear_i,
   output logic [PAGE_W-1:0]                  page_o,
   output logic [PAGE_BYTES-1:0]              mask_o,
   output logic [PAGE_BYTES-1:0][BYTE_W-1:0]  data_o
);

   logic [PAGE_W-1:0]                 page_q;
   logic [OFF_W-1:0]                  slot_q;
   logic [PAGE_BYTES-1:0]             mask_q;
   logic [PAGE_BYTES-1:0][BYTE_W-1:0] stage_q;

   // Page and slot pointer: captured on load, pointer steps on each byte
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         page_q <= '0;
         slot_q <= '0;
      end else if (op_i == OP_LOAD) begin
         page_q <= start_addr_i[ADDR_W-1:OFF_W];
         slot_q <= start_addr_i[OFF_W-1:0];
      end else if (op_i == OP_BYTE) begin
         // power-of-two page: natural overflow wraps inside the page
         slot_q <= slot_q + OFF_W'(1);
      end
   end

   // Valid mask
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
      end else if (clear_i || op_i == OP_ABORT || op_i == OP_LOAD) begin
         mask_q <= '0;
      end else if (op_i == OP_BYTE) begin
         mask_q[slot_q] <= 1'b1;
      end
   end

   // Staging storage, one lane per slot
   for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q[s] <= '0;
         end else if (op_i == OP_BYTE && slot_q == OFF_W'(s)) begin
            stage_q[s] <= byte_i;
         end
      end
   end

   assign page_o = page_q;
   assign mask_o = mask_q;
   assign data_o = stage_q;

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
   parameter int unsigned TWR_CYCLES = 40,
   localparam int unsigned CNT_W     = $clog2(TWR_CYCLES + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   logic [CNT_W-1:0] left_q;
   logic             busy_q;
   logic             last;

   assign last = busy_q && (left_q == CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            left_q <= CNT_W'(TWR_CYCLES);
         end
      end else if (last) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign busy_o = busy_q;
   assign done_o = last;

endmodule

// File: rtl/pwb_array.sv
module pwb_array
   import page_wrbuf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned RD_LATENCY = 0,
   localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
   localparam int unsigned PAGE_W    = ADDR_W - OFF_W,
   localparam int unsigned NUM_PAGES = 1 << PAGE_W
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic                               wr_en_i,
   input  logic [PAGE_W-1:0]                  wr_page_i,
   input  logic [PAGE_BYTES-1:0]              wr_mask_i,
   input  logic [PAGE_BYTES-1:0][BYTE_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0]                  rd_addr_i,
   output logic [BYTE_W-1:0]                  rd_data_o
);

   logic [PAGE_W-1:0]                 rd_page;
   logic [OFF_W-1:0]                  rd_slot;
   logic [PAGE_BYTES-1:0][BYTE_W-1:0] lane_rd;
   logic [BYTE_W-1:0]                 rd_sel;

   assign rd_page = rd_addr_i[ADDR_W-1:OFF_W];
   assign rd_slot = rd_addr_i[OFF_W-1:0];

   // One byte-wide column per slot; a whole page row is written in one edge
   for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_lane
      logic [BYTE_W-1:0] col_q [NUM_PAGES];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int p = 0; p < NUM_PAGES; p++) begin
               col_q[p] <= '1;
            end
         end else if (wr_en_i && wr_mask_i[l]) begin
            col_q[wr_page_i] <= wr_data_i[l];
         end
      end

      assign lane_rd[l] = col_q[rd_page];
   end

   assign rd_sel = lane_rd[rd_slot];

   if (RD_LATENCY == 0) begin : g_rd_comb
      assign rd_data_o = rd_sel;
   end else begin : g_rd_reg
      logic [BYTE_W-1:0] rd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rd_q <= '1;
         else         rd_q <= rd_sel;
      end
      assign rd_data_o = rd_q;
   end

endmodule

// File: rtl/page_wrbuf.sv
module page_wrbuf
   import page_wrbuf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned TWR_CYCLES = 40,
   parameter int unsigned RD_LATENCY = 0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                load_i,
   input  logic [ADDR_W-1:0]   start_addr_i,
   input  logic                byte_valid_i,
   input  logic [7:0]          byte_i,
   input  logic                abort_i,
   input  logic                commit_i,
   output logic                busy_o,
   input  logic [ADDR_W-1:0]   rd_addr_i,
   output logic [7:0]          rd_data_o
);

   localparam int unsigned OFF_W  = $clog2(PAGE_BYTES);
   localparam int unsigned PAGE_W = ADDR_W - OFF_W;

   // Elaboration-time parameter checks
   if (PAGE_BYTES != 32 && PAGE_BYTES != 64) begin : g_bad_page
      $error("page_wrbuf: PAGE_BYTES must be 32 or 64");
   end
   if (ADDR_W <= OFF_W || ADDR_W > 16) begin : g_bad_addr
      $error("page_wrbuf: ADDR_W must exceed the slot width and stay at most 16");
   end
   if (TWR_CYCLES < 1) begin : g_bad_twr
      $error("page_wrbuf: TWR_CYCLES must be at least 1");
   end
   if (RD_LATENCY > 1) begin : g_bad_rd
      $error("page_wrbuf: RD_LATENCY must be 0 or 1");
   end

   pwb_op_e                           op;
   logic                              busy;
   logic                              done;
   logic                              go;
   logic [PAGE_W-1:0]                 fill_page;
   logic [PAGE_BYTES-1:0]             fill_mask;
   logic [PAGE_BYTES-1:0][BYTE_W-1:0] fill_data;

   // Inputs are only decoded while idle
   assign op = busy ? OP_IDLE : pick_op(abort_i, commit_i, load_i, byte_valid_i);
   assign go = (op == OP_COMMIT) && (|fill_mask);

   pwb_loader #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_load (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .op_i         (op),
      .start_addr_i (start_addr_i),
      .byte_i       (byte_i),
      .clear_i      (done),
      .page_o       (fill_page),
      .mask_o       (fill_mask),
      .data_o       (fill_data)
   );

   pwb_timer #(
      .TWR_CYCLES (TWR_CYCLES)
   ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (go),
      .busy_o  (busy),
      .done_o  (done)
   );

   pwb_array #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .RD_LATENCY (RD_LATENCY)
   ) u_array (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (done),
      .wr_page_i (fill_page),
      .wr_mask_i (fill_mask),
      .wr_data_i (fill_data),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

   assign busy_o = busy;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned PAGE_BYTES = 32,
   parameter int unsigned TWR_CYCLES = 40,
   parameter int unsigned RD_LATENCY = 0
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  busy_i,
   input logic                  commit_i,
   input logic                  abort_i,
   input logic [PAGE_BYTES-1:0] mask_i,
   input logic [ADDR_W-1:0]     rd_addr_i,
   input logic [7:0]            rd_data_i
);

   // Length of the current busy run, compared when it ends
   int unsigned run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     run_q <= 0;
      else if (busy_i) run_q <= run_q + 1;
      else             run_q <= 0;
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && $past(busy_i)) |-> (run_q == TWR_CYCLES)); // R5

   AST_COMMIT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && commit_i && !abort_i && (|mask_i)) |=> busy_i); // R5

   AST_NO_EMPTY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && (abort_i || (commit_i && mask_i == '0))) |=> !busy_i); // R7

   AST_ABORT_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && abort_i) |=> (mask_i == '0)); // R7

   AST_MASK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |=> (!busy_i || mask_i == $past(mask_i))); // R8

   AST_CLEAR_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && $past(busy_i)) |-> (mask_i == '0)); // R6

   if (RD_LATENCY == 0) begin : g_quiet
      AST_ARRAY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (busy_i && $past(busy_i) && $stable(rd_addr_i)) |-> $stable(rd_data_i)); // R5
   end

endmodule

bind page_wrbuf pwb_checker #(
   .ADDR_W     (ADDR_W),
   .PAGE_BYTES (PAGE_BYTES),
   .TWR_CYCLES (TWR_CYCLES),
   .RD_LATENCY (RD_LATENCY)
) u_pwb_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .busy_i    (busy_o),
   .commit_i  (commit_i),
   .abort_i   (abort_i),
   .mask_i    (fill_mask),
   .rd_addr_i (rd_addr_i),
   .rd_data_i (rd_data_o)
);

// File: tb/test_page_wrbuf.sv
`timescale 1ns/1ps
module test_page_wrbuf;

   localparam int ADDR_W = 10;
   localparam int PB     = 32;
   localparam int TWR    = 40;
   localparam int NBYTES = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_in = 1'b0;
   logic [ADDR_W-1:0] addr_in = '0;
   logic              valid_in = 1'b0;
   logic [7:0]        data_in = '0;
   logic              abort_in = 1'b0;
   logic              commit_in = 1'b0;
   logic              busy;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [7:0]        rd_data;

   always #2.5 clk = ~clk;

   page_wrbuf #(
      .ADDR_W(ADDR_W), .PAGE_BYTES(PB), .TWR_CYCLES(TWR), .RD_LATENCY(0)
   ) i_page_wrbuf (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load_in), .start_addr_i(addr_in),
      .byte_valid_i(valid_in), .byte_i(data_in), .abort_i(abort_in),
      .commit_i(commit_in), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
   );

   int tests = 0;
   int fails = 0;

   // Reference model, built from the requirements
   logic [7:0] ref_mem [NBYTES];
   logic [7:0] m_buf [PB];
   bit [PB-1:0] m_mask;
   int m_page, m_ptr, m_rem;
   bit m_busy;

   // Scoreboard queues
   int         q_addr[$];
   logic [7:0] q_exp[$];
   string      q_tag[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected items, presents the address, compares the read data
   initial begin
      forever begin
         @(negedge clk);
         if (q_addr.size() > 0) begin
            int a;
            logic [7:0] e;
            string t;
            a = q_addr.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            rd_addr = a[ADDR_W-1:0];
            #1;
            check(rd_data === e, t, int'(rd_data), int'(e));
         end
      end
   end

   task automatic expect_page(input int pg, input string tag);
      for (int o = 0; o < PB; o++) begin
         q_addr.push_back(pg * PB + o);
         q_exp.push_back(ref_mem[pg * PB + o]);
         q_tag.push_back(tag);
      end
      wait (q_addr.size() == 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic apply_write();
      for (int o = 0; o < PB; o++)
         if (m_mask[o]) ref_mem[m_page * PB + o] = m_buf[o];
      m_mask = '0;
   endtask

   // One clock of stimulus; called at a falling edge, returns at the next one
   task automatic step(input bit ab, input bit cm, input bit ld, input int addr,
                       input bit st, input logic [7:0] d, input string tag);
      abort_in = ab; commit_in = cm; load_in = ld;
      addr_in = addr[ADDR_W-1:0]; valid_in = st; data_in = d;
      @(negedge clk);
      abort_in = 1'b0; commit_in = 1'b0; load_in = 1'b0; valid_in = 1'b0;
      if (m_busy) begin
         if (m_rem > 0) begin
            check(busy === 1'b1, {tag, " R5/R8 busy held"}, int'(busy), 1);
            m_rem--;
         end else begin
            check(busy === 1'b0, {tag, " R5 busy ends after TWR"}, int'(busy), 0);
            apply_write();
            m_busy = 1'b0;
         end
      end else if (ab) begin
         m_mask = '0;
         check(busy === 1'b0, {tag, " R7 abort starts nothing"}, int'(busy), 0);
      end else if (cm) begin
         if (m_mask != '0) begin
            check(busy === 1'b1, {tag, " R5 busy after commit"}, int'(busy), 1);
            m_busy = 1'b1;
            m_rem = TWR - 1;
         end else begin
            check(busy === 1'b0, {tag, " R7 empty commit"}, int'(busy), 0);
         end
      end else if (ld) begin
         m_page = addr / PB;
         m_ptr = addr % PB;
         m_mask = '0;
      end else if (st) begin
         m_buf[m_ptr] = d;
         m_mask[m_ptr] = 1'b1;
         m_ptr = (m_ptr + 1) % PB;
      end
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0, 8'h00, "idle"); endtask
   task automatic load(input int a);  step(0, 0, 1, a, 0, 8'h00, "load"); endtask
   task automatic put(input logic [7:0] d); step(0, 0, 0, 0, 1, d, "byte"); endtask
   task automatic commit(); step(0, 1, 0, 0, 0, 8'h00, "commit"); endtask
   task automatic settle(); while (m_busy) idle(); endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NBYTES; i++) ref_mem[i] = 8'hFF;
      m_mask = '0; m_page = 0; m_ptr = 0; m_busy = 1'b0; m_rem = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(busy === 1'b0, "R1 busy low after reset", int'(busy), 0);
      expect_page(0, "R1 erased page 0");
      expect_page(31, "R1 erased page 31");

      // R5/R6/R10: short burst from slot 0
      load(3 * PB);
      for (int i = 0; i < 4; i++) put(8'h10 + 8'(i));
      commit();
      settle();
      expect_page(3, "R6 short burst page 3");

      // R2/R3: burst starting at slot 30 wraps inside page 7
      load(7 * PB + 30);
      for (int i = 0; i < 5; i++) put(8'hA0 + 8'(i));
      commit();
      settle();
      expect_page(7, "R3 wrap inside page 7");
      expect_page(8, "R2 next page 8 untouched");

      // R4: 40 bytes into a 32-byte page, later bytes replace earlier ones
      load(10 * PB + 4);
      for (int i = 0; i < 40; i++) put(8'(i + 1));
      commit();
      settle();
      expect_page(10, "R4 overflow page 10");

      // R6: one-byte rewrite keeps the other bytes of page 3
      load(3 * PB + 2);
      put(8'h5C);
      commit();
      settle();
      expect_page(3, "R6 partial rewrite page 3");

      // R7: abort then commit
      load(12 * PB);
      put(8'h77); put(8'h78);
      step(1, 0, 0, 0, 0, 8'h00, "abort");
      commit();
      repeat (3) idle();
      check(busy === 1'b0, "R7 no cycle after abort", int'(busy), 0);
      expect_page(12, "R7 aborted page 12 unchanged");

      // R7: commit with nothing staged
      load(13 * PB);
      commit();
      expect_page(13, "R7 empty commit page 13");

      // R8: inputs during busy are ignored
      load(14 * PB);
      put(8'hC1); put(8'hC2);
      commit();
      put(8'hEE);
      load(20 * PB);
      commit();
      step(1, 0, 0, 0, 0, 8'h00, "abort in busy");
      settle();
      expect_page(14, "R8 busy-time byte ignored page 14");
      expect_page(20, "R8 busy-time load ignored page 20");
      commit();
      check(busy === 1'b0, "R8 busy-time strobes left mask empty", int'(busy), 0);
      put(8'hC3);
      commit();
      settle();
      expect_page(14, "R8 pointer and page kept page 14");

      // R9: abort beats commit
      load(16 * PB);
      put(8'h31); put(8'h32); put(8'h33);
      step(1, 1, 0, 0, 0, 8'h00, "abort+commit R9");
      commit();
      check(busy === 1'b0, "R9 abort won over commit", int'(busy), 0);
      expect_page(16, "R9 page 16 unchanged");

      // R9: commit beats byte
      load(17 * PB);
      put(8'h41); put(8'h42);
      step(0, 1, 0, 0, 1, 8'h43, "commit+byte R9");
      settle();
      expect_page(17, "R9 commit won over byte page 17");

      // R9: load beats byte
      step(0, 0, 1, 18 * PB, 1, 8'h55, "load+byte R9");
      put(8'h66);
      commit();
      settle();
      expect_page(18, "R9 load won over byte page 18");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule